// File: doc/BRIEF.md
# Watchdog Timer with Power-of-Two Timeout Extension

This block is a watchdog that runs on a free-running slow oscillator clock. A base divider turns every `BASE_DIV` oscillator cycles into one base tick. A postscaler counts those ticks. A 4-bit period select picks how many ticks, from 1 up to 32,768 in powers of two, must pass before the watchdog expires. With the default divider of 128 and a nominal 32 kHz oscillator, the timeout runs from about 4 ms to about 131 s.

Firmware keeps the watchdog from expiring by pulsing the clear strobe. Entering sleep through the sleep strobe also restarts the count, and so does any clock-failure indication. The watchdog runs when either the hard configuration enable or a software-writable enable bit is set. The software bit only matters while the configuration enable is low.

On expiry the block pulses a reset request while the system is awake. While the system is asleep it pulses a wake-up request instead. In both cases it also raises a sticky timeout flag.

Top module: `wdog_top`

## Requirements
- R1: With both counters starting from zero and the watchdog enabled, the request pulse appears `BASE_DIV * 2^period_sel` oscillator edges later. After a pulse the count restarts from zero, so pulses then repeat with exactly that interval. `period_sel` value k selects 2^k ticks, for k from 0 to 15.
- R2: A request is a one-cycle pulse. It goes out on `rst_req` if `asleep` was 0 on the expiring edge, and on `wake_req` if `asleep` was 1. The two are never high together.
- R3: `to_flag` goes high on the same edge as a request pulse. It stays high until a synchronized clear or sleep strobe, or a reset, clears it.
- R4: `clr_stb` and `sleep_stb` each pass through a two-flop synchronizer and then zero both counters. For a one-cycle strobe first sampled on edge E0, the next pulse appears on edge E0 + 2 + `BASE_DIV * 2^period_sel`.
- R5: While `clk_fail` is held high, the counters stay at zero and no pulse occurs. After it falls (first sampled low on edge Ea), the next pulse appears on edge Ea + 1 + `BASE_DIV * 2^period_sel`.
- R6: The watchdog is enabled when `cfg_force_on` is 1 or `sw_en_q` is 1. With `cfg_force_on` at 1, a `sw_en_q` of 0 has no effect and timeouts still occur.
- R7: While disabled, the counters are held at zero and no request is issued, and `to_flag` keeps its value. When the enable comes from a software write captured on edge E0, the first pulse appears on edge E0 + `BASE_DIV * 2^period_sel`.
- R8: The software enable bit loads `sw_en_wd` on an edge where `sw_en_we` is 1. Its value is readable on `sw_en_q` after that edge. Reset clears it to 0.
- R9: A change of `period_sel` does not clear the counters and acts at the next base tick. If the tick count already reached is at or above the new limit, the watchdog expires on that next tick. If the new limit is higher, counting continues toward it from the count already reached.
- R10: A synchronous reset drives `rst_req`, `wake_req`, `to_flag` and `sw_en_q` to 0 and clears the counters and synchronizers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_force_on | input | 1 | Hard enable; when 1 the watchdog always runs |
| period_sel | input | SEL_W | Timeout select; value k selects 2^k base ticks |
| sw_en_we | input | 1 | Write strobe for the software enable bit |
| sw_en_wd | input | 1 | Write data for the software enable bit |
| sw_en_q | output | 1 | Current software enable bit |
| clr_stb | input | 1 | Clear-watchdog strobe (asynchronous) |
| sleep_stb | input | 1 | Sleep-entry strobe (asynchronous) |
| clk_fail | input | 1 | Clock-failure indication (asynchronous) |
| asleep | input | 1 | System is in sleep or another power-managed mode |
| rst_req | output | 1 | One-cycle device reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| to_flag | output | 1 | Sticky timeout status |

## Verification
The bench builds the block with `BASE_DIV` set to 4 and keeps a 4-bit period select and two synchronizer stages. The short divider makes timeouts of up to 2^13 ticks affordable. It also makes the per-tick timing of a period-select change, at or around a given tick count, observable within a few cycles. The exact edge counts through the synchronizer and after an enable write are checked against those parameters. Random select values, sleep states and strobe choices are mixed with directed cases for a held clock failure, a disabled state, and raising and lowering the period select in mid-count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Asynchronous control inputs that restart the count.
  typedef struct packed {
    logic cfail;
    logic slp;
    logic clr;
  } wdog_ctl_s;

  localparam int CTL_W = $bits(wdog_ctl_s);

endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/wdog_basediv.sv
module wdog_basediv #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/wdog_postscale.sv
module wdog_postscale #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             fire
);

  localparam int PS_W = (1 << SEL_W) - 1;

  logic [PS_W-1:0] cnt;
  logic [PS_W-1:0] limit;
  logic [PS_W:0]   pow;
  logic [PS_W:0]   pow_m1;

  // Limit is 2^sel - 1 ticks already counted.
  always_comb begin
    pow      = '0;
    pow[sel] = 1'b1;
    pow_m1   = pow - (PS_W+1)'(1);
    limit    = pow_m1[PS_W-1:0];
  end

  assign fire = tick && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (fire) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + PS_W'(1);
    end
  end

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int BASE_DIV    = 128,
  parameter int SEL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_force_on,
  input  logic [SEL_W-1:0] period_sel,
  input  logic             sw_en_we,
  input  logic             sw_en_wd,
  output logic             sw_en_q,
  input  logic             clr_stb,
  input  logic             sleep_stb,
  input  logic             clk_fail,
  input  logic             asleep,
  output logic             rst_req,
  output logic             wake_req,
  output logic             to_flag
);

  wdog_ctl_s ctl_raw;
  wdog_ctl_s ctl_s;
  logic      restart;
  logic      enabled;
  logic      run;
  logic      tick;
  logic      fire;

  assign ctl_raw = '{cfail: clk_fail, slp: sleep_stb, clr: clr_stb};

  wdog_sync #(
    .WIDTH (CTL_W),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (ctl_raw),
    .q  (ctl_s)
  );

  assign restart = ctl_s.clr | ctl_s.slp | ctl_s.cfail;
  assign enabled = cfg_force_on | sw_en_q;
  assign run     = enabled & ~restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_en_q <= 1'b0;
    end else if (sw_en_we) begin
      sw_en_q <= sw_en_wd;
    end
  end

  wdog_basediv #(
    .DIV(BASE_DIV)
  ) u_base (
    .clk (clk),
    .rst (rst),
    .run (run),
    .tick(tick)
  );

  wdog_postscale #(
    .SEL_W(SEL_W)
  ) u_post (
    .clk (clk),
    .rst (rst),
    .run (run),
    .tick(tick),
    .sel (period_sel),
    .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      to_flag  <= 1'b0;
    end else begin
      rst_req  <= fire & ~asleep;
      wake_req <= fire & asleep;
      if (ctl_s.clr || ctl_s.slp) begin
        to_flag <= 1'b0;
      end else if (fire) begin
        to_flag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdog_checks.sv
module wdog_checks (
  input logic clk,
  input logic rst,
  input logic cfg_force_on,
  input logic sw_en_we,
  input logic sw_en_wd,
  input logic sw_en_q,
  input logic asleep,
  input logic rst_req,
  input logic wake_req,
  input logic to_flag
);

  assert_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(rst_req && wake_req));

  assert_rst_single_R2: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  assert_wake_single_R2: assert property (@(posedge clk) disable iff (rst)
    wake_req |=> !wake_req);

  assert_wake_asleep_R2: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(asleep));

  assert_rst_awake_R2: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> !$past(asleep));

  assert_flag_with_req_R3: assert property (@(posedge clk) disable iff (rst)
    (rst_req || wake_req) |-> to_flag);

  assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    $past(!cfg_force_on && !sw_en_q) |-> !(rst_req || wake_req));

  assert_sw_write_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sw_en_we)) |-> (sw_en_q == $past(sw_en_wd)));

  assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rst_req && !wake_req && !to_flag && !sw_en_q));

endmodule

bind wdog_top wdog_checks u_checks (
  .clk         (clk),
  .rst         (rst),
  .cfg_force_on(cfg_force_on),
  .sw_en_we    (sw_en_we),
  .sw_en_wd    (sw_en_wd),
  .sw_en_q     (sw_en_q),
  .asleep      (asleep),
  .rst_req     (rst_req),
  .wake_req    (wake_req),
  .to_flag     (to_flag)
);

// File: tb/sim_wdog_top.sv
module sim_wdog_top;

  localparam int CLK_PERIOD = 10;
  localparam int BDIV       = 4;
  localparam int SW         = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_force_on;
  logic [SW-1:0] period_sel;
  logic          sw_en_we, sw_en_wd, sw_en_q;
  logic          clr_stb, sleep_stb, clk_fail, asleep;
  logic          rst_req, wake_req, to_flag;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_top #(
    .BASE_DIV   (BDIV),
    .SEL_W      (SW),
    .SYNC_STAGES(2)
  ) u0 (
    .clk         (clk),
    .rst         (rst),
    .cfg_force_on(cfg_force_on),
    .period_sel  (period_sel),
    .sw_en_we    (sw_en_we),
    .sw_en_wd    (sw_en_wd),
    .sw_en_q     (sw_en_q),
    .clr_stb     (clr_stb),
    .sleep_stb   (sleep_stb),
    .clk_fail    (clk_fail),
    .asleep      (asleep),
    .rst_req     (rst_req),
    .wake_req    (wake_req),
    .to_flag     (to_flag)
  );

  function automatic int span(input int sel);
    return BDIV << sel;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_strobe(input int which, input logic v);
    case (which)
      0:       clr_stb   = v;
      1:       sleep_stb = v;
      default: clk_fail  = v;
    endcase
  endtask

  task automatic write_sw(input logic v);
    sw_en_we = 1'b1;
    sw_en_wd = v;
    @(negedge clk);
    sw_en_we = 1'b0;
  endtask

  // One-cycle strobe, optional period change at negedge switch_n, then wait for a pulse.
  task automatic strobe_run(input int which, input int switch_n, input logic [SW-1:0] new_sel,
                            input int limit, output int n_hit, output bit was_wake,
                            output bit flag_low3);
    n_hit     = -1;
    was_wake  = 1'b0;
    flag_low3 = 1'b0;
    set_strobe(which, 1'b1);
    for (int n = 1; n <= limit; n++) begin
      @(negedge clk);
      if (n == 1) set_strobe(which, 1'b0);
      if (n == 3) flag_low3 = !to_flag;
      if (n >= 3 && (rst_req || wake_req)) begin
        n_hit    = n;
        was_wake = wake_req;
        break;
      end
      if (n == switch_n) period_sel = new_sel;
    end
  endtask

  task automatic wait_next(input int limit, output int n_hit, output bit was_wake);
    n_hit    = -1;
    was_wake = 1'b0;
    for (int n = 1; n <= limit; n++) begin
      @(negedge clk);
      if (rst_req || wake_req) begin
        n_hit    = n;
        was_wake = wake_req;
        break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before the bench completed");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int  hit, d, sel_r, which_r;
    bit  wk, fl, slp_r;
    int  seen;

    void'($urandom(32'd24681));
    rst = 1'b1; cfg_force_on = 1'b0; period_sel = '0;
    sw_en_we = 1'b0; sw_en_wd = 1'b0;
    clr_stb = 1'b0; sleep_stb = 1'b0; clk_fail = 1'b0; asleep = 1'b0;
    repeat (5) @(negedge clk);
    check(!rst_req && !wake_req && !to_flag && !sw_en_q, "R10 reset state",
          {rst_req, wake_req, to_flag, sw_en_q}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R8 / R7: software enable write starts the count from zero.
    period_sel = 4'd2;
    d = span(2);
    write_sw(1'b1);
    check(sw_en_q == 1'b1, "R8 sw enable readback", sw_en_q, 1);
    wait_next(d + 10, hit, wk);
    check(hit + 1 == d + 1, "R7 first pulse after enable write", hit + 1, d + 1);
    check(to_flag == 1'b1, "R3 flag set with pulse", to_flag, 1);

    // R7: disabled -> no pulses, flag keeps its value.
    write_sw(1'b0);
    check(sw_en_q == 1'b0, "R8 sw enable cleared", sw_en_q, 0);
    seen = 0;
    repeat (4 * d) begin
      @(negedge clk);
      if (rst_req || wake_req) seen++;
    end
    check(seen == 0, "R7 no pulse while disabled", seen, 0);
    check(to_flag == 1'b1, "R3 flag sticky while idle", to_flag, 1);

    // R6: configuration enable overrides a cleared software bit.
    cfg_force_on = 1'b1;
    period_sel   = 4'd3;
    d = span(3);
    strobe_run(0, 0, '0, d + 10, hit, wk, fl);
    check(fl, "R3 flag cleared by clear strobe", !fl, 0);
    check(hit == d + 3, "R6 R4 timeout with cfg enable and sw off", hit, d + 3);
    check(!wk, "R2 reset request while awake", wk, 0);
    wait_next(d + 10, hit, wk);
    check(hit == d, "R1 free-running interval", hit, d);

    // R2: wake-up request while asleep, restarted by sleep strobe.
    asleep     = 1'b1;
    period_sel = 4'd1;
    d = span(1);
    strobe_run(1, 0, '0, d + 10, hit, wk, fl);
    check(hit == d + 3, "R4 sleep strobe restart", hit, d + 3);
    check(wk, "R2 wake request while asleep", wk, 1);
    check(fl, "R3 flag cleared by sleep strobe", !fl, 0);
    asleep = 1'b0;

    // R5: held clock failure.
    period_sel = 4'd2;
    d = span(2);
    clk_fail = 1'b1;
    seen = 0;
    for (int n = 1; n <= 4 * d; n++) begin
      @(negedge clk);
      if (n >= 3 && (rst_req || wake_req)) seen++;
    end
    check(seen == 0, "R5 no pulse during clock failure", seen, 0);
    clk_fail = 1'b0;
    wait_next(d + 10, hit, wk);
    check(hit == d + 2, "R5 restart after clock failure", hit, d + 2);

    // R9: lowering the select below the current count fires on the next tick.
    period_sel = 4'd5;
    strobe_run(0, 3 + 10 * BDIV, 4'd2, span(5) + 10, hit, wk, fl);
    check(hit == 3 + 11 * BDIV, "R9 lowered select fires next tick", hit, 3 + 11 * BDIV);

    // R9: raising the select keeps the count already reached.
    period_sel = 4'd1;
    strobe_run(0, 3 + BDIV + 1, 4'd3, span(3) + 10, hit, wk, fl);
    check(hit == span(3) + 3, "R9 raised select without clearing", hit, span(3) + 3);

    // R1: long tap.
    period_sel = 4'd13;
    d = span(13);
    strobe_run(0, 0, '0, d + 10, hit, wk, fl);
    check(hit == d + 3, "R1 long tap timeout", hit, d + 3);

    // Random mix: R1, R2, R4.
    for (int it = 0; it < 10; it++) begin
      sel_r   = int'($urandom_range(0, 6));
      slp_r   = 1'($urandom_range(0, 1));
      which_r = int'($urandom_range(0, 1));
      period_sel = SW'(sel_r);
      asleep     = slp_r;
      d = span(sel_r);
      strobe_run(which_r, 0, '0, d + 10, hit, wk, fl);
      check(hit == d + 3, "R4 random strobe restart", hit, d + 3);
      check(wk == slp_r, "R2 random request kind", wk, slp_r);
      wait_next(d + 10, hit, wk);
      check(hit == d, "R1 random interval", hit, d);
    end
    asleep = 1'b0;

    // R10: reset in mid-run.
    write_sw(1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(sw_en_q == 1'b0 && to_flag == 1'b0, "R10 mid-run reset", {sw_en_q, to_flag}, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule